// File: doc/BRIEF.md
# Register-list command executor

This block runs a list of display-register programming commands. A fetch stage hands it the list as a stream of 32-bit words, two words per instruction, lower word first. The executor decodes each instruction from the upper word's opcode and either issues register writes on a write master port, waits for a number of microsecond ticks or vertical-blank pulses, raises a sticky program interrupt, or does nothing. An indexed write is a variable-length instruction: its lower word holds a count N and is followed by N data words that all go to one register offset, plus one zero padding word when N is odd so that the next instruction starts on an 8-byte boundary.

Both streaming edges use valid/ready. A word on the input is consumed on a clock edge where `in_valid` and `in_ready` are both high; the fetch stage must hold `in_word` stable while `in_valid` is high and `in_ready` is low. A write on the master port completes on an edge where `wr_valid` and `wr_ready` are both high; the executor keeps address, data and byte enables stable until then and accepts no further input word while a write is outstanding. Waits also hold `in_ready` low, which back-pressures the fetch stage.

The interrupt and error flags are sticky status bits cleared by a one-cycle pulse on their clear inputs; a set and a clear in the same cycle leave the flag set. The `busy` output lets the surrounding logic see when a command list has drained.

Top module: `regcmd_exec`

## Requirements
- R1: Instructions arrive as two words, lower word then upper word; the opcode is upper-word bits 31:24. While no instruction is in progress `in_ready` is high, and it stays high after the lower word so the upper word can be taken.
- R2: Opcode 0x00 (no-op) issues no write, changes no flag and leaves the executor idle after the upper word is accepted.
- R3: Opcode 0x01 issues exactly one write with `wr_addr` = upper-word bits 19:0, `wr_data` = lower word and `wr_be` = upper-word bits 23:20, where `wr_be` bit n enables byte lane n (data bits 8n+7:8n); 0xF writes the whole word.
- R4: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `wr_be` hold their values, and `in_ready` is low whenever `wr_valid` is high.
- R5: Opcode 0x09 takes a count N from the low CNT_W bits of the lower word and issues one write per following data word, in arrival order, all at offset upper-word bits 19:0 with `wr_be` = 0xF.
- R6: After an indexed write with odd N, exactly one padding word is consumed and discarded; with even N (including 0) none is, and the next word is the lower word of the next instruction.
- R7: Opcode 0x02 waits for N pulses of `us_tick`, N being the low CNT_W bits of the lower word, counting pulses from the cycle after the upper word is accepted; `busy` falls in the cycle after the Nth pulse, and N = 0 ends the instruction at once.
- R8: Opcode 0x04 waits in the same way for N pulses of `vblank_pulse`; `us_tick` pulses do not advance it.
- R9: Opcode 0x07 sets `prog_irq` in the cycle after the upper word is accepted; the flag stays set until an `irq_clr` pulse, and a set in the same cycle as a clear wins.
- R10: Any other opcode sets the sticky `err_flag` (cleared by `err_clr`) and the instruction is dropped with no write; the following instruction executes normally.
- R11: `busy` is high from the edge that accepts a lower word until the instruction completes: the write handshake for opcode 0x01, the last write handshake (and pad word) for 0x09, the last counted pulse for a wait, or the upper word for other opcodes.
- R12: During and right after reset `busy`, `wr_valid`, `prog_irq` and `err_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word valid |
| in_ready | output | 1 | Executor can take a word |
| in_word | input | 32 | Instruction word |
| wr_valid | output | 1 | Register write request |
| wr_ready | input | 1 | Register write accepted |
| wr_addr | output | 20 | Register offset |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Byte-lane enables |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| vblank_pulse | input | 1 | One-cycle pulse per vertical blank |
| irq_clr | input | 1 | Clear pulse for the program interrupt |
| err_clr | input | 1 | Clear pulse for the error flag |
| prog_irq | output | 1 | Sticky program interrupt |
| err_flag | output | 1 | Sticky unknown-opcode error |
| busy | output | 1 | Instruction in progress |

## Verification
The bench builds the block with its default CNT_W of 16, which is wide enough for every count the bench uses, so all wait lengths and indexed-write lengths (0, 2, 3) are exercised without truncation. A write-ready pattern that stalls every other cycle is used for an indexed burst, which brings the hold-while-stalled rule and the ordering of data words under back-pressure within reach of the checker module.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;
  localparam int WORD_W = 32;
  localparam int OFS_W  = 20;
  localparam int BE_W   = 4;
  localparam int OP_LSB = 24;
  localparam int BE_LSB = 20;

  typedef enum logic [7:0] {
    OP_NOP     = 8'h00,
    OP_WRITE   = 8'h01,
    OP_WAIT_US = 8'h02,
    OP_WAIT_VB = 8'h04,
    OP_IRQ     = 8'h07,
    OP_IDX     = 8'h09
  } op_t;

  typedef enum logic [2:0] {
    ST_LO, ST_HI, ST_WR, ST_IDX, ST_PAD, ST_WAIT
  } st_t;
endpackage

// File: rtl/regcmd_wr_slot.sv
module regcmd_wr_slot
  import regcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFS_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [BE_W-1:0]  ld_be,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [OFS_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [BE_W-1:0]  wr_be
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_be    <= '0;
    end else if (load) begin
      wr_valid <= 1'b1;
      wr_addr  <= ld_addr;
      wr_data  <= ld_data;
      wr_be    <= ld_be;
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/regcmd_timer.sv
module regcmd_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_vb,
  input  logic             us_tick,
  input  logic             vblank_pulse,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             vb_q;
  logic             evt;

  assign evt    = active_q && (vb_q ? vblank_pulse : us_tick);
  assign expire = evt && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      vb_q     <= 1'b0;
    end else if (load) begin
      cnt_q    <= load_val;
      active_q <= 1'b1;
      vb_q     <= load_vb;
    end else if (evt) begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/regcmd_flags.sv
module regcmd_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/regcmd_exec.sv
module regcmd_exec
  import regcmd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [OFS_W-1:0]  wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [BE_W-1:0]   wr_be,
  input  logic              us_tick,
  input  logic              vblank_pulse,
  input  logic              irq_clr,
  input  logic              err_clr,
  output logic              prog_irq,
  output logic              err_flag,
  output logic              busy
);
  localparam logic [BE_W-1:0] BE_ALL = '1;

  st_t               st;
  logic [WORD_W-1:0] lo_q;
  logic [CNT_W-1:0]  rem_q;
  logic              odd_q;
  logic [OFS_W-1:0]  idx_ofs_q;

  logic              acc, hi_acc;
  logic [7:0]        op;
  logic              op_known;
  logic [CNT_W-1:0]  lo_cnt;
  logic              lo_zero;
  logic              wr_load;
  logic [OFS_W-1:0]  ld_addr;
  logic [WORD_W-1:0] ld_data;
  logic [BE_W-1:0]   ld_be;
  logic              tmr_load, tmr_expire;
  logic              idx_done;
  logic [1:0]        flag_set, flag_clr, flag_q;

  assign op      = in_word[WORD_W-1:OP_LSB];
  assign acc     = in_valid && in_ready;
  assign hi_acc  = acc && (st == ST_HI);
  assign lo_cnt  = lo_q[CNT_W-1:0];
  assign lo_zero = (lo_cnt == '0);

  always_comb begin
    case (op)
      OP_NOP, OP_WRITE, OP_WAIT_US, OP_WAIT_VB, OP_IRQ, OP_IDX: op_known = 1'b1;
      default: op_known = 1'b0;
    endcase
  end

  always_comb begin
    case (st)
      ST_LO, ST_HI, ST_PAD: in_ready = 1'b1;
      ST_IDX:               in_ready = (rem_q != '0) && !wr_valid;
      default:              in_ready = 1'b0;
    endcase
  end

  // write slot feed: plain write from the decoded pair, or one indexed data word
  assign wr_load = (hi_acc && op == OP_WRITE) || (acc && st == ST_IDX);
  assign ld_addr = (st == ST_HI) ? in_word[OFS_W-1:0] : idx_ofs_q;
  assign ld_data = (st == ST_HI) ? lo_q : in_word;
  assign ld_be   = (st == ST_HI) ? in_word[BE_LSB+BE_W-1:BE_LSB] : BE_ALL;

  regcmd_wr_slot u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_load),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .ld_be    (ld_be),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_be    (wr_be)
  );

  assign tmr_load = hi_acc && (op == OP_WAIT_US || op == OP_WAIT_VB) && !lo_zero;

  regcmd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (tmr_load),
    .load_val     (lo_cnt),
    .load_vb      (op == OP_WAIT_VB),
    .us_tick      (us_tick),
    .vblank_pulse (vblank_pulse),
    .expire       (tmr_expire)
  );

  assign flag_set = {hi_acc && !op_known, hi_acc && op == OP_IRQ};
  assign flag_clr = {err_clr, irq_clr};

  regcmd_flags #(.N(2)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (flag_clr),
    .q     (flag_q)
  );

  assign prog_irq = flag_q[0];
  assign err_flag = flag_q[1];

  assign idx_done = (rem_q == '0) && (!wr_valid || wr_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_LO;
      lo_q      <= '0;
      rem_q     <= '0;
      odd_q     <= 1'b0;
      idx_ofs_q <= '0;
    end else begin
      case (st)
        ST_LO: if (acc) begin
          lo_q <= in_word;
          st   <= ST_HI;
        end
        ST_HI: if (acc) begin
          case (op)
            OP_WRITE: st <= ST_WR;
            OP_WAIT_US, OP_WAIT_VB: st <= lo_zero ? ST_LO : ST_WAIT;
            OP_IDX: begin
              rem_q     <= lo_cnt;
              odd_q     <= lo_cnt[0];
              idx_ofs_q <= in_word[OFS_W-1:0];
              st        <= lo_zero ? ST_LO : ST_IDX;
            end
            default: st <= ST_LO;
          endcase
        end
        ST_WR: if (wr_valid && wr_ready) st <= ST_LO;
        ST_IDX: begin
          if (acc) rem_q <= rem_q - CNT_W'(1);
          else if (idx_done) st <= odd_q ? ST_PAD : ST_LO;
        end
        ST_PAD:  if (acc) st <= ST_LO;
        ST_WAIT: if (tmr_expire) st <= ST_LO;
        default: st <= ST_LO;
      endcase
    end
  end

  assign busy = (st != ST_LO);
endmodule

// File: rtl/regcmd_exec_chk.sv
module regcmd_exec_chk
  import regcmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [OFS_W-1:0]  wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic [BE_W-1:0]   wr_be,
  input logic              irq_clr,
  input logic              err_clr,
  input logic              prog_irq,
  input logic              err_flag,
  input logic              busy
);
  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be));

  assert_no_accept_during_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !in_ready);

  assert_write_inside_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);

  assert_idle_takes_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> in_ready);

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_irq && !irq_clr |=> prog_irq);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);

  assert_reset_quiet_R12: assert property (@(posedge clk)
    !rst_n |=> !busy && !wr_valid && !prog_irq && !err_flag);
endmodule

bind regcmd_exec regcmd_exec_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .wr_be    (wr_be),
  .irq_clr  (irq_clr),
  .err_clr  (err_clr),
  .prog_irq (prog_irq),
  .err_flag (err_flag),
  .busy     (busy)
);

// File: tb/regcmd_exec_test.sv
module regcmd_exec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [19:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;
  logic        us_tick = 1'b0;
  logic        vblank_pulse = 1'b0;
  logic        irq_clr = 1'b0;
  logic        err_clr = 1'b0;
  logic        prog_irq, err_flag, busy;

  regcmd_exec uut (.*);

  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // captured write handshakes
  logic [19:0] cap_addr [0:63];
  logic [31:0] cap_data [0:63];
  logic [3:0]  cap_be   [0:63];
  int cap_n = 0;
  bit stall_mode = 0;

  always @(negedge clk) begin
    wr_ready = stall_mode ? ~wr_ready : 1'b1;
    if (rst_n && wr_valid && wr_ready && cap_n < 64) begin
      cap_addr[cap_n] = wr_addr;
      cap_data[cap_n] = wr_data;
      cap_be[cap_n]   = wr_be;
      cap_n++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // called and returns at a negative edge
  task automatic send_word(input logic [31:0] w);
    in_word  = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_ins(input logic [31:0] lo, input logic [31:0] hi);
    send_word(lo);
    send_word(hi);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      if (!busy && !wr_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic pulse_us();
    us_tick = 1'b1; @(negedge clk); us_tick = 1'b0;
  endtask

  task automatic pulse_vb();
    vblank_pulse = 1'b1; @(negedge clk); vblank_pulse = 1'b0;
  endtask

  // {lower word, upper word, expected offset, expected data, expected enables}
  localparam logic [119:0] VEC [0:5] = '{
    {32'h12345678, 32'h01F00010, 20'h00010, 32'h12345678, 4'hF},
    {32'hA5A5A5A5, 32'h01500ABC, 20'h00ABC, 32'hA5A5A5A5, 4'h5},
    {32'hDEADBEEF, 32'h018FFFFF, 20'hFFFFF, 32'hDEADBEEF, 4'h8},
    {32'h00000000, 32'h01100004, 20'h00004, 32'h00000000, 4'h1},
    {32'hFFFFFFFF, 32'h01000100, 20'h00100, 32'hFFFFFFFF, 4'h0},
    {32'hCAFEF00D, 32'h01300200, 20'h00200, 32'hCAFEF00D, 4'h3}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    // R12 reset state
    check(busy == 0 && wr_valid == 0, "R12 busy/wr_valid in reset", {30'b0, busy, wr_valid}, 0);
    check(prog_irq == 0 && err_flag == 0, "R12 flags in reset", {30'b0, prog_irq, err_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && in_ready == 1, "R12 idle after reset", {30'b0, busy, in_ready}, 32'h1);

    // R3 table of plain writes
    foreach (VEC[k]) begin
      base = cap_n;
      send_ins(VEC[k][119:88], VEC[k][87:56]);
      wait_idle();
      check(cap_n == base + 1, "R3 one write", cap_n - base, 1);
      check(cap_addr[base] == VEC[k][55:36], "R3 offset", {12'b0, cap_addr[base]}, {12'b0, VEC[k][55:36]});
      check(cap_data[base] == VEC[k][35:4], "R3 data", cap_data[base], VEC[k][35:4]);
      check(cap_be[base] == VEC[k][3:0], "R3 byte enables", {28'b0, cap_be[base]}, {28'b0, VEC[k][3:0]});
    end

    // R1 / R11: after lower word, busy and still ready for upper word
    base = cap_n;
    send_word(32'h11112222);
    check(busy == 1, "R11 busy after lower word", {31'b0, busy}, 1);
    check(in_ready == 1, "R1 ready for upper word", {31'b0, in_ready}, 1);
    send_word(32'h01F00040);
    wait_idle();
    check(cap_n == base + 1 && cap_data[base] == 32'h11112222, "R1 pair assembled", cap_data[base], 32'h11112222);

    // R2 no-op
    base = cap_n;
    send_ins(32'h55555555, 32'h00000000);
    check(busy == 0, "R2 no-op idle", {31'b0, busy}, 0);
    repeat (3) @(negedge clk);
    check(cap_n == base && !prog_irq && !err_flag, "R2 no side effect", cap_n - base, 0);

    // R5 / R6 indexed, odd count, followed by a plain write
    base = cap_n;
    send_ins(32'd3, 32'h09000ABC);
    send_word(32'hAAAA0001);
    send_word(32'hAAAA0002);
    send_word(32'hAAAA0003);
    send_word(32'h00000000);
    send_ins(32'h77777777, 32'h01F00123);
    wait_idle();
    check(cap_n == base + 4, "R5 odd count writes", cap_n - base, 4);
    for (int i = 0; i < 3; i++) begin
      check(cap_addr[base+i] == 20'h00ABC && cap_be[base+i] == 4'hF, "R5 indexed offset/enables",
            {8'b0, cap_be[base+i], cap_addr[base+i]}, {8'b0, 4'hF, 20'h00ABC});
      check(cap_data[base+i] == 32'hAAAA0001 + i, "R5 indexed order", cap_data[base+i], 32'hAAAA0001 + i);
    end
    check(cap_addr[base+3] == 20'h00123 && cap_data[base+3] == 32'h77777777, "R6 pad skipped",
          cap_data[base+3], 32'h77777777);

    // R6 even count under write back-pressure, no pad
    stall_mode = 1;
    base = cap_n;
    send_ins(32'd2, 32'h09000300);
    send_word(32'hBBBB0001);
    send_word(32'hBBBB0002);
    send_ins(32'h88888888, 32'h01F00301);
    wait_idle();
    stall_mode = 0;
    @(negedge clk);
    check(cap_n == base + 3, "R6 even count writes", cap_n - base, 3);
    check(cap_data[base] == 32'hBBBB0001 && cap_data[base+1] == 32'hBBBB0002, "R4 order under stall",
          cap_data[base+1], 32'hBBBB0002);
    check(cap_addr[base+2] == 20'h00301 && cap_data[base+2] == 32'h88888888, "R6 even no pad",
          cap_data[base+2], 32'h88888888);

    // R6 zero count
    base = cap_n;
    send_ins(32'd0, 32'h09000400);
    check(busy == 0, "R6 zero count idle", {31'b0, busy}, 0);
    send_ins(32'h99999999, 32'h01F00401);
    wait_idle();
    check(cap_n == base + 1 && cap_data[base] == 32'h99999999, "R6 zero count next instr",
          cap_data[base], 32'h99999999);

    // R7 microsecond wait of 3
    send_ins(32'd3, 32'h02000000);
    check(busy == 1 && in_ready == 0, "R7 waiting", {30'b0, busy, in_ready}, 32'h2);
    pulse_us();
    pulse_us();
    check(busy == 1, "R7 still waiting after 2 ticks", {31'b0, busy}, 1);
    pulse_us();
    check(busy == 0, "R7 done after 3 ticks", {31'b0, busy}, 0);

    // R7 zero wait
    send_ins(32'd0, 32'h02000000);
    check(busy == 0, "R7 zero wait immediate", {31'b0, busy}, 0);

    // R8 vblank wait of 2, microsecond ticks ignored
    send_ins(32'd2, 32'h04000000);
    pulse_us(); pulse_us(); pulse_us();
    check(busy == 1, "R8 us ticks ignored", {31'b0, busy}, 1);
    pulse_vb();
    check(busy == 1, "R8 after 1 vblank", {31'b0, busy}, 1);
    pulse_vb();
    check(busy == 0, "R8 done after 2 vblanks", {31'b0, busy}, 0);

    // R9 interrupt
    send_ins(32'd0, 32'h07000000);
    check(prog_irq == 1 && busy == 0, "R9 irq set", {30'b0, prog_irq, busy}, 32'h2);
    repeat (3) @(negedge clk);
    check(prog_irq == 1, "R9 irq sticky", {31'b0, prog_irq}, 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    check(prog_irq == 0, "R9 irq cleared", {31'b0, prog_irq}, 0);

    // R10 unknown opcode then a normal write
    base = cap_n;
    send_ins(32'h12121212, 32'h33F00500);
    check(err_flag == 1 && prog_irq == 0, "R10 error set", {30'b0, err_flag, prog_irq}, 32'h2);
    send_ins(32'h34343434, 32'h01F00501);
    wait_idle();
    check(cap_n == base + 1 && cap_data[base] == 32'h34343434, "R10 skipped, next executes",
          cap_data[base], 32'h34343434);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    check(err_flag == 0, "R10 error cleared", {31'b0, err_flag}, 0);

    finish_run();
  end
endmodule